// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Word Reader

This block reads 16-bit words from a three-wire serial EEPROM. A single-cycle start pulse carrying an address launches one read. The block raises chip select and shifts out a read command, most significant bit first. It then clocks in sixteen data bits and returns the word together with a one-cycle done pulse. A mode input chooses between the small device, which has 6-bit word addresses, and the large device, which has 8-bit word addresses. The same input sets how many command bits are sent.

A second request input fetches a 48-bit station identifier. This runs three reads back to back, from a parameterised base word upward. The lowest word fills the least significant sixteen bits of the result. The serial clock half-period is a parameter counted in system clocks. The default is 50 cycles, which is 1 µs at 50 MHz. While a transfer or its closing idle gap is in progress, a busy output is held high and new requests are dropped.

Top module: `mw_eeprom_reader`

## Requirements
- R1: While rst_ni is low, cs_o, sk_o, di_o, busy_o, done_o and mac_done_o are all 0.
- R2: A read sends the bits 1,1,0 and then the address, MSB first. With wide_i=0 the address is addr_i[5:0], giving 9 command bits. With wide_i=1 it is addr_i[7:0], giving 11 bits. di_o changes only while sk_o is low, so each bit is stable across its sk_o rising edge.
- R3: With wide_i=0, addr_i[7:6] have no effect on the command sent or on the word returned.
- R4: After the command, exactly 16 further sk_o pulses occur. do_i is sampled at the end of each high half and assembled MSB first. data_o holds the word when done_o pulses for one cycle.
- R5: Every high and low half of sk_o inside a transaction lasts HALF_CYC system clocks.
- R6: cs_o stays high from the first command bit to the last data bit. In the done_o cycle, cs_o, sk_o and di_o are all low. cs_o then stays low for at least HALF_CYC cycles, and busy_o falls exactly HALF_CYC cycles after done_o.
- R7: busy_o is high from the cycle after an accepted start. A start_i pulse while busy_o is high is ignored and produces no transaction.
- R8: A mac_start_i pulse reads words MAC_BASE, MAC_BASE+1 and MAC_BASE+2. It then pulses mac_done_o for one cycle, with mac_o = {word(MAC_BASE+2), word(MAC_BASE+1), word(MAC_BASE)}.
- R9: When start_i and mac_start_i arrive in the same idle cycle, the three-word fetch is performed and the single read is dropped.
- R10: sk_o is never high while cs_o is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wide_i | input | 1 | 1 selects 8-bit word addresses, 0 selects 6-bit |
| start_i | input | 1 | Single-word read request pulse |
| addr_i | input | 8 | Word address for start_i |
| mac_start_i | input | 1 | Three-word station identifier fetch request |
| busy_o | output | 1 | Transfer or closing gap in progress |
| done_o | output | 1 | One-cycle pulse when a word is complete |
| data_o | output | 16 | Most recently read word |
| mac_done_o | output | 1 | One-cycle pulse when the identifier is complete |
| mac_o | output | 48 | Assembled station identifier |
| cs_o | output | 1 | EEPROM chip select |
| sk_o | output | 1 | EEPROM serial clock |
| di_o | output | 1 | Serial data toward the EEPROM |
| do_i | input | 1 | Serial data from the EEPROM |

## Verification
A behavioural EEPROM answers on the serial pins and decodes the command it receives. Each read is therefore checked on what the wire carried as well as on data_o. A design that sent the wrong command length, or left the top address bits live in small mode, returns the word for a different address. One that sampled do_i off by a clock pulse returns a shifted word.

The half-period monitor and the gap measurement catch a divider that is off by one cycle, or a busy flag that drops before chip select has rested. A start pulse issued mid-transfer must leave the transaction count unchanged. A simultaneous start and fetch request must yield three transactions and an identifier, not one plain read. An asynchronous reset issued in the middle of a read must return every line low, and a following read must still succeed.

// File: rtl/mw_pkg.sv
package mw_pkg;
  localparam int ADDR_W       = 8;
  localparam int NARROW_AW    = 6;
  localparam int DATA_W       = 16;
  localparam int OPC_W        = 3;
  localparam logic [OPC_W-1:0] RD_OPC = 3'b110;
  localparam int CMD_W_NARROW = OPC_W + NARROW_AW;
  localparam int CMD_W_WIDE   = OPC_W + ADDR_W;
  localparam int MAC_WORDS    = 3;
  localparam int MAC_W        = MAC_WORDS * DATA_W;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CMD_LO, ST_CMD_HI, ST_DAT_LO, ST_DAT_HI, ST_GAP
  } mw_state_e;
endpackage

// File: rtl/mw_tick.sv
module mw_tick #(
  parameter int HALF_CYC = 50
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o
);
  localparam int CW = $clog2(HALF_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(HALF_CYC - 1);

  logic [CW-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!run_i || tick_o)  cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/mw_shift.sv
module mw_shift
  import mw_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              wide_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              shift_i,
  output logic              cmd_next_o,
  input  logic              cap_i,
  input  logic              do_i,
  output logic [DATA_W-1:0] word_o
);
  localparam int PAD_W = ADDR_W - NARROW_AW;

  logic [CMD_W_WIDE-1:0] cmd_q;
  logic [DATA_W-1:0]     dat_q;
  logic [CMD_W_WIDE-1:0] cmd_load;

  // left-aligned: narrow mode drops addr[7:6] and pads at the tail
  always_comb begin
    if (wide_i) cmd_load = {RD_OPC, addr_i};
    else        cmd_load = {RD_OPC, addr_i[NARROW_AW-1:0], {PAD_W{1'b0}}};
  end

  assign cmd_next_o = cmd_q[CMD_W_WIDE-2];
  assign word_o     = dat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q <= '0;
      dat_q <= '0;
    end else begin
      if (load_i)       cmd_q <= cmd_load;
      else if (shift_i) cmd_q <= {cmd_q[CMD_W_WIDE-2:0], 1'b0};
      if (cap_i)        dat_q <= {dat_q[DATA_W-2:0], do_i};
    end
  end
endmodule

// File: rtl/mw_seq.sv
module mw_seq
  import mw_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic wide_i,
  input  logic tick_i,
  input  logic cmd_next_i,
  output logic load_o,
  output logic shift_o,
  output logic cap_o,
  output logic busy_o,
  output logic cs_o,
  output logic sk_o,
  output logic di_o,
  output logic done_o
);
  localparam int CW = $clog2(DATA_W);

  mw_state_e     state_q;
  logic [CW-1:0] cnt_q;
  logic          last;

  assign last    = (cnt_q == '0);
  assign load_o  = start_i && (state_q == ST_IDLE);
  assign shift_o = tick_i && (state_q == ST_CMD_HI) && !last;
  assign cap_o   = tick_i && (state_q == ST_DAT_HI);
  assign busy_o  = (state_q != ST_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      cs_o    <= 1'b0;
      sk_o    <= 1'b0;
      di_o    <= 1'b0;
      done_o  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (load_o) begin
          state_q <= ST_CMD_LO;
          cs_o    <= 1'b1;
          sk_o    <= 1'b0;
          di_o    <= RD_OPC[OPC_W-1];
          cnt_q   <= wide_i ? CW'(CMD_W_WIDE - 1) : CW'(CMD_W_NARROW - 1);
        end
        ST_CMD_LO: if (tick_i) begin
          sk_o    <= 1'b1;
          state_q <= ST_CMD_HI;
        end
        ST_CMD_HI: if (tick_i) begin
          sk_o <= 1'b0;
          if (last) begin
            di_o    <= 1'b0;
            cnt_q   <= CW'(DATA_W - 1);
            state_q <= ST_DAT_LO;
          end else begin
            di_o    <= cmd_next_i;
            cnt_q   <= cnt_q - 1'b1;
            state_q <= ST_CMD_LO;
          end
        end
        ST_DAT_LO: if (tick_i) begin
          sk_o    <= 1'b1;
          state_q <= ST_DAT_HI;
        end
        ST_DAT_HI: if (tick_i) begin
          sk_o <= 1'b0;
          if (last) begin
            cs_o    <= 1'b0;
            done_o  <= 1'b1;
            state_q <= ST_GAP;
          end else begin
            cnt_q   <= cnt_q - 1'b1;
            state_q <= ST_DAT_LO;
          end
        end
        ST_GAP: if (tick_i) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mw_mac_fetch.sv
module mw_mac_fetch
  import mw_pkg::*;
#(
  parameter int BASE_ADDR = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mac_start_i,
  input  logic              eng_busy_i,
  input  logic              eng_done_i,
  input  logic [DATA_W-1:0] word_i,
  output logic              req_o,
  output logic [ADDR_W-1:0] req_addr_o,
  output logic              active_o,
  output logic [MAC_W-1:0]  mac_o,
  output logic              mac_done_o
);
  localparam int IW = $clog2(MAC_WORDS);

  logic                              active_q;
  logic                              pend_q;
  logic [IW-1:0]                     idx_q;
  logic [MAC_WORDS-1:0][DATA_W-1:0]  words_q;

  assign req_o      = active_q && pend_q && !eng_busy_i;
  assign req_addr_o = ADDR_W'(BASE_ADDR) + ADDR_W'(idx_q);
  assign active_o   = active_q;
  assign mac_o      = words_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q   <= 1'b0;
      pend_q     <= 1'b0;
      idx_q      <= '0;
      words_q    <= '0;
      mac_done_o <= 1'b0;
    end else begin
      mac_done_o <= 1'b0;
      if (!active_q && mac_start_i && !eng_busy_i) begin
        active_q <= 1'b1;
        pend_q   <= 1'b1;
        idx_q    <= '0;
      end
      if (req_o) pend_q <= 1'b0;
      if (active_q && eng_done_i) begin
        words_q[idx_q] <= word_i;
        if (idx_q == IW'(MAC_WORDS - 1)) begin
          active_q   <= 1'b0;
          mac_done_o <= 1'b1;
        end else begin
          idx_q  <= idx_q + 1'b1;
          pend_q <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/mw_eeprom_reader.sv
module mw_eeprom_reader
  import mw_pkg::*;
#(
  parameter int HALF_CYC = 50,
  parameter int MAC_BASE = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wide_i,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              mac_start_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] data_o,
  output logic              mac_done_o,
  output logic [MAC_W-1:0]  mac_o,
  output logic              cs_o,
  output logic              sk_o,
  output logic              di_o,
  input  logic              do_i
);
  logic              eng_busy, eng_start, tick;
  logic              load, shift, cap, cmd_next;
  logic              mac_req, mac_active, user_go;
  logic [ADDR_W-1:0] mac_addr, eng_addr;

  assign busy_o    = eng_busy || mac_active;
  assign user_go   = start_i && !busy_o && !mac_start_i;
  assign eng_start = user_go || mac_req;
  assign eng_addr  = mac_req ? mac_addr : addr_i;

  mw_tick #(.HALF_CYC(HALF_CYC)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (eng_busy),
    .tick_o (tick)
  );

  mw_seq u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (eng_start),
    .wide_i     (wide_i),
    .tick_i     (tick),
    .cmd_next_i (cmd_next),
    .load_o     (load),
    .shift_o    (shift),
    .cap_o      (cap),
    .busy_o     (eng_busy),
    .cs_o       (cs_o),
    .sk_o       (sk_o),
    .di_o       (di_o),
    .done_o     (done_o)
  );

  mw_shift u_shift (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .wide_i     (wide_i),
    .addr_i     (eng_addr),
    .shift_i    (shift),
    .cmd_next_o (cmd_next),
    .cap_i      (cap),
    .do_i       (do_i),
    .word_o     (data_o)
  );

  mw_mac_fetch #(.BASE_ADDR(MAC_BASE)) u_mac (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .mac_start_i (mac_start_i),
    .eng_busy_i  (eng_busy),
    .eng_done_i  (done_o),
    .word_i      (data_o),
    .req_o       (mac_req),
    .req_addr_o  (mac_addr),
    .active_o    (mac_active),
    .mac_o       (mac_o),
    .mac_done_o  (mac_done_o)
  );
endmodule

// File: rtl/mw_eeprom_reader_chk.sv
module mw_eeprom_reader_chk #(
  parameter int HALF_CYC = 50
) (
  input logic clk_i,
  input logic rst_ni,
  input logic cs_o,
  input logic sk_o,
  input logic di_o,
  input logic done_o,
  input logic busy_o,
  input logic mac_done_o
);
  localparam int GW = $clog2(HALF_CYC + 1);

  logic [GW-1:0] gap_q;
  logic [5:0]    edges_q;
  logic          sk_prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q     <= GW'(HALF_CYC);
      edges_q   <= '0;
      sk_prev_q <= 1'b0;
    end else begin
      sk_prev_q <= sk_o;
      if (cs_o)                       gap_q <= '0;
      else if (gap_q < GW'(HALF_CYC)) gap_q <= gap_q + 1'b1;
      if (!cs_o)                      edges_q <= '0;
      else if (sk_o && !sk_prev_q)    edges_q <= edges_q + 1'b1;
    end
  end

  assert_sk_in_cs_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sk_o |-> cs_o);
  assert_di_stable_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sk_o && $past(sk_o)) |-> $stable(di_o));
  assert_pulse_count_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cs_o) |-> (edges_q == 6'd25 || edges_q == 6'd27));
  assert_done_pulse_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_lines_low_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!cs_o && !sk_o && !di_o));
  assert_cs_gap_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cs_o) |-> (gap_q >= GW'(HALF_CYC)));
  assert_idle_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !cs_o);
  assert_mac_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mac_done_o |=> !mac_done_o);
endmodule

bind mw_eeprom_reader mw_eeprom_reader_chk #(.HALF_CYC(HALF_CYC)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cs_o       (cs_o),
  .sk_o       (sk_o),
  .di_o       (di_o),
  .done_o     (done_o),
  .busy_o     (busy_o),
  .mac_done_o (mac_done_o)
);

// File: tb/mw_eeprom_reader_bench.sv
module mw_eeprom_reader_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HC = 3;
  localparam int NV = 6;
  // {wide, addr}
  localparam logic [8:0] VEC [NV] = '{9'h000, 9'h03F, 9'h1FF, 9'h181, 9'h0C5, 9'h15A};

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic wide_i = 1'b0, start_i = 1'b0, mac_start_i = 1'b0;
  logic [7:0] addr_i = '0;
  logic busy_o, done_o, mac_done_o, cs_o, sk_o, di_o;
  logic do_i = 1'b0;
  logic [15:0] data_o;
  logic [47:0] mac_o;

  int n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mw_eeprom_reader #(.HALF_CYC(HC), .MAC_BASE(7)) u_mw_eeprom_reader (
    .clk_i(clk), .rst_ni(rst_ni), .wide_i(wide_i), .start_i(start_i),
    .addr_i(addr_i), .mac_start_i(mac_start_i), .busy_o(busy_o),
    .done_o(done_o), .data_o(data_o), .mac_done_o(mac_done_o), .mac_o(mac_o),
    .cs_o(cs_o), .sk_o(sk_o), .di_o(di_o), .do_i(do_i)
  );

  function automatic logic [15:0] mem(input logic [7:0] a);
    return {a, ~a} ^ 16'hA5C3;
  endfunction

  // EEPROM model
  int edges = 0, cs_rises = 0;
  logic [10:0] m_cmd = '0;
  logic [15:0] m_word = '0;

  always @(posedge cs_o) begin
    edges = 0;
    m_cmd = '0;
    cs_rises++;
  end

  always @(posedge sk_o) begin
    if (cs_o) begin
      int ncmd;
      ncmd = wide_i ? 11 : 9;
      edges++;
      if (edges <= ncmd) begin
        m_cmd = {m_cmd[9:0], di_o};
        if (edges == ncmd) m_word = mem(wide_i ? m_cmd[7:0] : {2'b00, m_cmd[5:0]});
      end else if (edges <= ncmd + 16) begin
        do_i <= m_word[15 - (edges - ncmd - 1)];
      end
    end
  end

  // half-period and sk/cs monitors
  int hp_run = 0, hp_chk = 0, hp_viol = 0, sk_viol = 0;
  bit hp_meas = 0;
  logic prev_sk = 1'b0;
  always @(negedge clk) begin
    if (sk_o && !cs_o) sk_viol++;
    if (!cs_o) begin
      hp_meas = 0;
      hp_run  = 0;
    end else if (sk_o != prev_sk) begin
      if (hp_meas) begin
        hp_chk++;
        if (hp_run != HC) hp_viol++;
      end
      hp_meas = 1;
      hp_run  = 1;
    end else hp_run++;
    prev_sk = sk_o;
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
  endtask

  task automatic wait_done(output bit seen);
    seen = 0;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (done_o) begin seen = 1; break; end
    end
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (busy_o && n < 2000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic pulse_start(input logic w, input logic [7:0] a);
    @(negedge clk);
    wide_i = w; addr_i = a; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog R7 actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    bit seen;
    int n, rises0;
    logic [7:0] ea;

    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1 lines", {cs_o, sk_o, di_o}, 3'b000);
    chk("R1 flags", {busy_o, done_o, mac_done_o}, 3'b000);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);

    // vector table
    for (int v = 0; v < NV; v++) begin
      logic w;
      w  = VEC[v][8];
      ea = w ? VEC[v][7:0] : {2'b00, VEC[v][5:0]};
      pulse_start(w, VEC[v][7:0]);
      chk("R7 busy after start", busy_o, 1'b1);
      wait_done(seen);
      chk("R4 done seen", seen, 1'b1);
      chk(VEC[v][7:6] != 2'b00 && !w ? "R3 masked data" : "R4 data", data_o, mem(ea));
      chk("R6 lines low at done", {cs_o, sk_o, di_o}, 3'b000);
      if (w) begin
        chk("R2 wide opcode", m_cmd[10:8], 3'b110);
        chk("R2 wide addr", m_cmd[7:0], ea);
        chk("R4 wide pulses", edges, 27);
      end else begin
        chk("R2 narrow opcode", m_cmd[8:6], 3'b110);
        chk("R3 narrow addr", m_cmd[5:0], ea[5:0]);
        chk("R4 narrow pulses", edges, 25);
      end
      wait_idle(n);
      chk("R6 gap length", n, HC);
    end

    // R7: start ignored while busy
    rises0 = cs_rises;
    pulse_start(1'b0, 8'h12);
    repeat (10) @(negedge clk);
    chk("R7 busy mid", busy_o, 1'b1);
    pulse_start(1'b0, 8'h2A);
    wait_done(seen);
    chk("R7 first data kept", data_o, mem(8'h12));
    wait_idle(n);
    repeat (HC * 4) @(negedge clk);
    chk("R7 single transaction", cs_rises - rises0, 1);

    // R8: station identifier fetch
    rises0 = cs_rises;
    @(negedge clk);
    wide_i = 1'b0; mac_start_i = 1'b1;
    @(negedge clk);
    mac_start_i = 1'b0;
    seen = 0;
    for (int i = 0; i < 5000; i++) begin
      if (mac_done_o) begin seen = 1; break; end
      @(negedge clk);
    end
    chk("R8 mac done", seen, 1'b1);
    chk("R8 mac value", mac_o, {mem(8'd9), mem(8'd8), mem(8'd7)});
    chk("R8 three reads", cs_rises - rises0, 3);
    wait_idle(n);

    // R9: simultaneous requests, fetch wins
    rises0 = cs_rises;
    @(negedge clk);
    wide_i = 1'b1; addr_i = 8'h20; start_i = 1'b1; mac_start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0; mac_start_i = 1'b0;
    seen = 0;
    for (int i = 0; i < 5000; i++) begin
      if (mac_done_o) begin seen = 1; break; end
      @(negedge clk);
    end
    chk("R9 fetch done", seen, 1'b1);
    chk("R9 fetch value", mac_o, {mem(8'd9), mem(8'd8), mem(8'd7)});
    chk("R9 three reads", cs_rises - rises0, 3);
    wait_idle(n);

    // R1: reset mid-transaction, then recover
    pulse_start(1'b1, 8'h77);
    repeat (15) @(negedge clk);
    rst_ni = 1'b0;
    #1;
    chk("R1 async lines", {cs_o, sk_o, di_o}, 3'b000);
    chk("R1 async busy", busy_o, 1'b0);
    @(negedge clk);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    pulse_start(1'b1, 8'h66);
    wait_done(seen);
    chk("R4 after reset", data_o, mem(8'h66));
    wait_idle(n);

    // R5, R10: monitors
    chk("R5 halves measured", hp_chk > 100, 1'b1);
    chk("R5 half period", hp_viol, 0);
    chk("R10 sk outside cs", sk_viol, 0);

    summary();
    $finish;
  end
endmodule